// File: doc/BRIEF.md
# Two-phase stepper step/direction translator

This block converts pulse-and-direction motion commands into drive codes for the two windings of a bipolar stepper motor. It keeps an electrical position on an eight-entry half-step wheel (45 degrees per entry). For each winding it produces a 3-bit current-magnitude code for a downstream DAC and a polarity bit. It also produces a decay-mode select for each winding and one global drive-enable.

Each rising edge on the step pin moves the position by one increment. The direction pin chooses the way round, and a resolution pin chooses half or full steps. The step, direction, resolution and hold pins are asynchronous to the clock and pass through a synchronizer first. After every move, each winding's decay mode is chosen by comparing its new magnitude with the one it had before.

An active-low hold pin parks the wheel at the home entry, turns the drive off and blocks stepping while it is low. The analog current loop, the sense comparators and the power bridges sit outside this block.

Top module: `stepper_xlate`

## Requirements
- R1: After `rst`, `drive_en` is 0, both level codes are 5 (71%), both polarity bits are 1 and both decay bits are 0. Position is home (entry 1).
- R2: Level codes are 0 = 0%, 5 = 71% and 7 = 100%. Polarity 1 means positive current and is also used when the level is 0. For wheel entry p, winding A takes entry p of this list and winding B takes entry (p-2) mod 8: 0:7/+, 1:5/+, 2:0/+, 3:5/-, 4:7/-, 5:5/-, 6:0/+, 7:5/+.
- R3: Each low-to-high transition of `step_in` while enabled moves the position once. The outputs change at the rising `clk` edge two cycles after the edge that first samples `step_in` high. With no such transition, the levels and polarities hold.
- R4: `dir_in` = 0 (clockwise) increases the position and `dir_in` = 1 (counterclockwise) decreases it. `dir_in` is sampled through the same synchronizer as `step_in` and used only at a step edge. A change of `dir_in` with no step edge leaves the outputs unchanged.
- R5: `half_sel` = 1 moves by 1. `half_sel` = 0 (full step) moves by 2 from an odd entry, and by 1 from an even entry so that the position lands on a diagonal (odd) entry.
- R6: At each move, a winding's decay bit becomes 0 (mixed) if its new level code is smaller than its previous one, and 1 (slow) if it is greater or equal.
- R7: While the synchronized `hold_n` is 0, `drive_en` is 0, the position is home, both decay bits are 0 and step edges are ignored. A `step_in` that is already high when hold is released causes no move.
- R8: The position wraps modulo 8 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_in | input | 1 | Step command, asynchronous; rising edge advances |
| dir_in | input | 1 | Direction, 0 clockwise, 1 counterclockwise |
| hold_n | input | 1 | Active-low hold: park at home, drive off |
| half_sel | input | 1 | 1 half-step, 0 full-step |
| drive_en | output | 1 | Global output enable |
| a_level | output | 3 | Winding A current-level code |
| a_pol | output | 1 | Winding A polarity, 1 positive |
| a_slow | output | 1 | Winding A decay, 1 slow, 0 mixed |
| b_level | output | 3 | Winding B current-level code |
| b_pol | output | 1 | Winding B polarity, 1 positive |
| b_slow | output | 1 | Winding B decay, 1 slow, 0 mixed |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer and home at entry 1. With those values the step latency is exactly two cycles after first sampling, and a behavioural model can track it edge for edge. The test covers full laps of the wheel in both directions and full steps taken from both odd and even entries. It also covers decay choices in all three outcomes (down, up and equal magnitude), and a step pin held high across the release of hold.

// File: rtl/stx_pkg.sv
package stx_pkg;
  localparam int POS_W = 3;
  localparam int LVL_W = 3;
  typedef logic [POS_W-1:0] pos_t;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_ZERO = 3'd0;
  localparam lvl_t LVL_MID  = 3'd5;
  localparam lvl_t LVL_FULL = 3'd7;
endpackage

// File: rtl/stx_sync.sv
module stx_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/stx_seq.sv
module stx_seq
  import stx_pkg::*;
#(
  parameter pos_t HOME_POS = 3'd1
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_ok,
  input  logic step_rise,
  input  logic dir_ccw,
  input  logic half_sel,
  output logic advance,
  output pos_t pos_nxt
);
  pos_t pos_q;
  pos_t delta;

  always_comb begin
    // full step from an even entry takes one increment to reach a diagonal
    delta = (!half_sel && pos_q[0]) ? pos_t'(2) : pos_t'(1);
    if (!hold_ok)     pos_nxt = HOME_POS;
    else if (dir_ccw) pos_nxt = pos_q - delta;
    else              pos_nxt = pos_q + delta;
  end

  assign advance = step_rise && hold_ok;

  always_ff @(posedge clk) begin
    if (rst || !hold_ok) pos_q <= HOME_POS;
    else if (advance)    pos_q <= pos_nxt;
  end
endmodule

// File: rtl/stx_phase.sv
module stx_phase
  import stx_pkg::*;
#(
  parameter pos_t OFFSET   = 3'd0,
  parameter pos_t HOME_POS = 3'd1
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_ok,
  input  logic advance,
  input  pos_t pos_nxt,
  output lvl_t level,
  output logic pol,
  output logic slow
);
  pos_t lut_pos;
  pos_t idx;
  lvl_t lut_lvl;
  logic lut_pol;

  always_comb begin
    lut_pos = (rst || !hold_ok) ? HOME_POS : pos_nxt;
    idx     = lut_pos - OFFSET;
    case (idx)
      3'd0:       begin lut_lvl = LVL_FULL; lut_pol = 1'b1; end
      3'd1, 3'd7: begin lut_lvl = LVL_MID;  lut_pol = 1'b1; end
      3'd2, 3'd6: begin lut_lvl = LVL_ZERO; lut_pol = 1'b1; end
      3'd3, 3'd5: begin lut_lvl = LVL_MID;  lut_pol = 1'b0; end
      default:    begin lut_lvl = LVL_FULL; lut_pol = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !hold_ok) begin
      level <= lut_lvl;
      pol   <= lut_pol;
      slow  <= 1'b0;
    end else if (advance) begin
      level <= lut_lvl;
      pol   <= lut_pol;
      slow  <= (lut_lvl >= level);
    end
  end
endmodule

// File: rtl/stepper_xlate.sv
module stepper_xlate
  import stx_pkg::*;
#(
  parameter int   SYNC_STAGES = 2,
  parameter pos_t HOME_POS    = 3'd1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       step_in,
  input  logic       dir_in,
  input  logic       hold_n,
  input  logic       half_sel,
  output logic       drive_en,
  output logic [2:0] a_level,
  output logic       a_pol,
  output logic       a_slow,
  output logic [2:0] b_level,
  output logic       b_pol,
  output logic       b_slow
);
  localparam int PHASES = 2;
  localparam int SYNC_W = 4;

  logic [SYNC_W-1:0] raw_bus, sync_bus;
  logic step_s, dir_s, half_s, hold_ok;
  logic step_d, step_rise, advance;
  pos_t pos_nxt;
  lvl_t ph_level [PHASES];
  logic ph_pol   [PHASES];
  logic ph_slow  [PHASES];

  assign raw_bus = {hold_n, half_sel, dir_in, step_in};

  stx_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_bus), .q(sync_bus)
  );

  assign {hold_ok, half_s, dir_s, step_s} = sync_bus;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_d   <= 1'b0;
      drive_en <= 1'b0;
    end else begin
      step_d   <= step_s;
      drive_en <= hold_ok;
    end
  end

  assign step_rise = step_s && !step_d;

  stx_seq #(.HOME_POS(HOME_POS)) u_seq (
    .clk(clk), .rst(rst), .hold_ok(hold_ok), .step_rise(step_rise),
    .dir_ccw(dir_s), .half_sel(half_s), .advance(advance), .pos_nxt(pos_nxt)
  );

  for (genvar g = 0; g < PHASES; g++) begin : g_phase
    stx_phase #(.OFFSET(pos_t'(2 * g)), .HOME_POS(HOME_POS)) u_phase (
      .clk(clk), .rst(rst), .hold_ok(hold_ok), .advance(advance),
      .pos_nxt(pos_nxt), .level(ph_level[g]), .pol(ph_pol[g]), .slow(ph_slow[g])
    );
  end

  assign a_level = ph_level[0];
  assign a_pol   = ph_pol[0];
  assign a_slow  = ph_slow[0];
  assign b_level = ph_level[1];
  assign b_pol   = ph_pol[1];
  assign b_slow  = ph_slow[1];
endmodule

// File: rtl/stx_checker.sv
module stx_checker
  import stx_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       step_rise,
  input logic       hold_ok,
  input logic       drive_en,
  input logic [2:0] a_level,
  input logic       a_pol,
  input logic       a_slow,
  input logic [2:0] b_level,
  input logic       b_pol,
  input logic       b_slow
);
  AST_HOLD_HOME: assert property (@(posedge clk) disable iff (rst)
    !hold_ok |=> (!drive_en && !a_slow && !b_slow && a_level == LVL_MID &&
                  b_level == LVL_MID && a_pol && b_pol)); // R7

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (hold_ok && !step_rise) |=> $stable({a_level, a_pol, b_level, b_pol})); // R3

  AST_DECAY_A: assert property (@(posedge clk) disable iff (rst)
    (hold_ok && step_rise) |=> (a_slow == (a_level >= $past(a_level)))); // R6

  AST_DECAY_B: assert property (@(posedge clk) disable iff (rst)
    (hold_ok && step_rise) |=> (b_slow == (b_level >= $past(b_level)))); // R6

  AST_MID_PAIR: assert property (@(posedge clk) disable iff (rst)
    drive_en |-> ((a_level == LVL_MID) == (b_level == LVL_MID))); // R2

  AST_NEVER_BOTH_ZERO: assert property (@(posedge clk) disable iff (rst)
    drive_en |-> !(a_level == LVL_ZERO && b_level == LVL_ZERO)); // R2
endmodule

bind stepper_xlate stx_checker u_chk (
  .clk(clk), .rst(rst), .step_rise(step_rise), .hold_ok(hold_ok),
  .drive_en(drive_en), .a_level(a_level), .a_pol(a_pol), .a_slow(a_slow),
  .b_level(b_level), .b_pol(b_pol), .b_slow(b_slow)
);

// File: tb/stepper_xlate_bench.sv
`timescale 1ns/1ps
module stepper_xlate_bench;
  logic clk = 0;
  logic rst = 1;
  logic step_in = 0, dir_in = 0, hold_n = 0, half_sel = 1;
  logic drive_en, a_pol, a_slow, b_pol, b_slow;
  logic [2:0] a_level, b_level;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  stepper_xlate u_stepper_xlate (
    .clk(clk), .rst(rst), .step_in(step_in), .dir_in(dir_in), .hold_n(hold_n),
    .half_sel(half_sel), .drive_en(drive_en), .a_level(a_level), .a_pol(a_pol),
    .a_slow(a_slow), .b_level(b_level), .b_pol(b_pol), .b_slow(b_slow)
  );

  // wheel entry values taken from the requirement list
  function automatic int wheel_lvl(int i);
    case (((i % 8) + 8) % 8)
      0, 4:    return 7;
      2, 6:    return 0;
      default: return 5;
    endcase
  endfunction
  function automatic int wheel_pol(int i);
    case (((i % 8) + 8) % 8)
      3, 4, 5: return 0;
      default: return 1;
    endcase
  endfunction

  // behavioural model: inputs reach the logic two edges after sampling
  int m_pos = 1, m_en = 0, m_sa = 0, m_sb = 0;
  int q_step[$], q_dir[$], q_half[$], q_hold[$];
  int m_prev_step = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_pos = 1; m_en = 0; m_sa = 0; m_sb = 0; m_prev_step = 0;
      q_step = '{0, 0}; q_dir = '{0, 0}; q_half = '{0, 0}; q_hold = '{0, 0};
    end else begin
      int s2, d2, f2, h2, delta, np;
      s2 = q_step[1]; d2 = q_dir[1]; f2 = q_half[1]; h2 = q_hold[1];
      if (!h2) begin
        m_pos = 1; m_sa = 0; m_sb = 0;
      end else if (s2 && !m_prev_step) begin
        delta = (!f2 && (m_pos % 2 == 1)) ? 2 : 1;
        np = d2 ? (m_pos - delta + 8) % 8 : (m_pos + delta) % 8;
        m_sa = (wheel_lvl(np) >= wheel_lvl(m_pos)) ? 1 : 0;
        m_sb = (wheel_lvl(np - 2) >= wheel_lvl(m_pos - 2)) ? 1 : 0;
        m_pos = np;
      end
      m_en = h2;
      m_prev_step = s2;
      q_step = '{int'(step_in), q_step[0]};
      q_dir  = '{int'(dir_in),  q_dir[0]};
      q_half = '{int'(half_sel), q_half[0]};
      q_hold = '{int'(hold_n),  q_hold[0]};
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the clock edge
  always @(posedge clk) begin
    #2;
    if (!rst && !finished) begin
      chk("R2 a_level", a_level, wheel_lvl(m_pos));
      chk("R2 a_pol",   a_pol,   wheel_pol(m_pos));
      chk("R2 b_level", b_level, wheel_lvl(m_pos - 2));
      chk("R2 b_pol",   b_pol,   wheel_pol(m_pos - 2));
      chk("R6 a_slow",  a_slow,  m_sa);
      chk("R6 b_slow",  b_slow,  m_sb);
      chk("R7 drive_en", drive_en, m_en);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int dir, int half);
    dir_in = dir[0]; half_sel = half[0];
    idle(1);
    step_in = 1; idle(4);
    step_in = 0; idle(4);
  endtask

  task automatic expect_out(string req, int al, int ap, int bl, int bp);
    chk(req, a_level, al); chk(req, a_pol, ap);
    chk(req, b_level, bl); chk(req, b_pol, bp);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    idle(5); rst = 0; idle(3);
    // R1: reset state
    chk("R1 en", drive_en, 0);
    expect_out("R1 home", 5, 1, 5, 1);
    chk("R1 slowA", a_slow, 0); chk("R1 slowB", b_slow, 0);

    hold_n = 1; idle(5);
    chk("R7 enable after release", drive_en, 1);

    // R3: one half step clockwise, with latency checked
    dir_in = 0; half_sel = 1; idle(1);
    step_in = 1;
    @(posedge clk); @(posedge clk); #2;
    expect_out("R3 not yet moved", 5, 1, 5, 1);
    @(posedge clk); #2;
    expect_out("R3 moved to entry 2", 0, 1, 7, 1);
    chk("R6 A down mixed", a_slow, 0); chk("R6 B up slow", b_slow, 1);
    idle(4); step_in = 0; idle(4);

    // R8: full lap forward
    for (int i = 0; i < 8; i++) pulse(0, 1);
    expect_out("R8 lap forward", 0, 1, 7, 1);

    // R4: direction change without a step edge
    dir_in = 1; idle(10);
    expect_out("R4 dir alone", 0, 1, 7, 1);

    pulse(1, 1);
    expect_out("R4 ccw to entry 1", 5, 1, 5, 1);
    chk("R6 A up slow", a_slow, 1); chk("R6 B down mixed", b_slow, 0);

    // R5: full steps from odd entries
    pulse(0, 0);
    expect_out("R5 full 1->3", 5, 0, 5, 1);
    chk("R6 equal slow A", a_slow, 1); chk("R6 equal slow B", b_slow, 1);
    pulse(0, 0);
    expect_out("R5 full 3->5", 5, 0, 5, 0);
    pulse(0, 1);
    expect_out("R5 half 5->6", 0, 1, 7, 0);
    // R5: full step from an even entry lands on a diagonal
    pulse(0, 0);
    expect_out("R5 full 6->7", 5, 1, 5, 0);
    pulse(1, 0);
    expect_out("R5 full ccw 7->5", 5, 0, 5, 0);

    // R8: wrap downward 5->3->1->7
    for (int i = 0; i < 3; i++) pulse(1, 0);
    expect_out("R8 wrap down to 7", 5, 1, 5, 0);

    // R7: hold parks at home and ignores steps
    hold_n = 0; idle(4);
    chk("R7 en off", drive_en, 0);
    expect_out("R7 parked", 5, 1, 5, 1);
    chk("R7 slowA", a_slow, 0); chk("R7 slowB", b_slow, 0);
    dir_in = 0; half_sel = 1;
    step_in = 1; idle(4); step_in = 0; idle(4);
    expect_out("R7 step ignored", 5, 1, 5, 1);
    step_in = 1; idle(4);
    hold_n = 1; idle(6);
    step_in = 0; idle(4);
    chk("R7 en back", drive_en, 1);
    expect_out("R7 held step no move", 5, 1, 5, 1);

    pulse(0, 1);
    expect_out("R3 stepping resumes", 0, 1, 7, 1);
    idle(4);
    summary();
  end
endmodule